// File: doc/BRIEF.md
# Exception Pending Control Register

This block is the software-visible pending-control word of a small exception controller. Software can make two system exceptions pending through it: a deferred supervisor-call exception and a system-timer exception. Each has a readable set bit and a separate write-only clear bit. The timer exception can also be made pending by a hardware tick. The supervisor-call exception can be made pending only by software.

The same word reports several pieces of controller status. It shows whether any external interrupt (exception number 16 and above) is pending. It gives the number of the best pending enabled exception after base-priority and fault masking. It gives the number of the exception now running. It also shows whether returning from that exception would reach thread level. The priority selector is combinational over a parameterised set of exception sources, so the reported number follows the inputs in the same cycle. The two internal pending bits change on the clock edge that takes a write.

Top module: `exc_pend_ctrl`

## Requirements
- R1: Writing 1 to bit 28 makes the supervisor-call exception (number 14) pending, and bit 28 reads back that state. Writing 0 to bit 28 has no effect. Input `exc_pend_i[14]` never changes this state, so a software write is the only way to set it.
- R2: Writing 1 to bit 27 clears the supervisor-call pending state. When bits 28 and 27 are both 1 in the same write, the exception ends up not pending.
- R3: Writing 1 to bit 26 makes the timer exception (number 15) pending. So does `exc_pend_i[15]` being high at a clock edge. Bit 26 reads back that state.
- R4: Writing 1 to bit 25 clears the timer pending state. This clear wins over a software set or a hardware set in the same cycle. Bit 25 always reads 0.
- R5: Bit 22 reads 1 exactly when any exception numbered 16 or above is pending, whether or not it is enabled.
- R6: Bits 17:12 give the number of the pending, enabled exception with the lowest priority value. On a tie in priority value, the lower exception number is chosen. The field reads 0 when no exception qualifies. Exception 0 is never a candidate.
- R7: When `basepri_i` is nonzero, an exception whose priority value is greater than or equal to `basepri_i` is not reported.
- R8: When `faultmask_i` is 1, no exception other than NMI (number 2) is reported. A pending NMI is always reported, regardless of its enable, its priority or either mask.
- R9: Bits 8:0 equal `act_num_i`. Bit 11 reads 1 when `act_cnt_i` is 0 or 1, and 0 otherwise.
- R10: Bits 31:29, 24, 23, 21:18 and 10:9 read 0, and writes to them have no effect. A write to any other address changes nothing, and a read of any other address returns 0.
- R11: After reset both internal pending states are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | ADDR_W | Register address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| exc_pend_i | input | NUM_EXC | Pending state per exception number (bit 15 is the timer tick, bit 14 is ignored) |
| exc_en_i | input | NUM_EXC | Enable per exception number |
| exc_prio_i | input | NUM_EXC*PRIO_W | Priority value per exception, exception n in bits n*PRIO_W upward |
| basepri_i | input | PRIO_W | Base-priority threshold, 0 = no masking |
| faultmask_i | input | 1 | Masks everything except NMI |
| act_num_i | input | 9 | Number of the active exception, 0 = thread mode |
| act_cnt_i | input | CNT_W | Count of active exceptions |

## Verification
The bench builds the block with 32 exception sources and a 3-bit priority field. With so few priority values, equal priorities are common, which exercises the tie-break on exception number. A base-priority threshold can also sit exactly on a pending source's value to test the boundary. Three priority patterns are used: uniform, rising with the number, and falling with the number. Combined with 16 external interrupt lines and the NMI, the fault mask, enables and the base-priority boundary, these reach every selection rule. Directed writes then cover the set/clear conflicts, the hardware timer tick and the reserved and off-address behaviour.

// File: rtl/epc_pkg.sv
// Package: shared constants for the exception pending control register.
// Assumes a 32-bit register word and exception numbers below 64.
package epc_pkg;
    localparam int NMI_NUM    = 2;
    localparam int SVC_NUM    = 14;
    localparam int TMR_NUM    = 15;
    localparam int IRQ_BASE   = 16;

    localparam int BIT_SV_SET = 28;
    localparam int BIT_SV_CLR = 27;
    localparam int BIT_TM_SET = 26;
    localparam int BIT_TM_CLR = 25;
    localparam int BIT_ISR    = 22;
    localparam int VP_LSB     = 12;
    localparam int VP_W       = 6;
    localparam int BIT_RTB    = 11;
    localparam int ACT_W      = 9;

    localparam logic [31:0] RSV_MASK = 32'hE1BC_0600;

    // Index of each software-controlled pending flop
    localparam int PB_SVC = 0;
    localparam int PB_TMR = 1;
    localparam int PB_N   = 2;
endpackage

// File: rtl/epc_pend_bits.sv
// Module: bank of set/clear pending flops.
// Each bit can be set by software or hardware and cleared by software;
// the clear wins over any set in the same cycle. Assumes synchronous reset.
module epc_pend_bits #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] hw_set,
    output logic [N-1:0] pend
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        // Hold one pending flag with clear-over-set priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (sw_clr[g])
                pend[g] <= 1'b0;
            else if (sw_set[g] || hw_set[g])
                pend[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/epc_prio_sel.sv
// Module: combinational selector of the best pending enabled exception.
// Lower priority value wins, ties go to the lower number. Nonzero base
// priority excludes values not better than it; the fault mask excludes all
// but NMI, which is always chosen when pending. Assumes NUM_EXC <= 64.
module epc_prio_sel
    import epc_pkg::*;
#(
    parameter int NUM_EXC = 32,
    parameter int PRIO_W  = 3
) (
    input  logic [NUM_EXC-1:0]        pend,
    input  logic [NUM_EXC-1:0]        en,
    input  logic [NUM_EXC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         basepri,
    input  logic                      faultmask,
    output logic [VP_W-1:0]           vect
);
    logic [PRIO_W-1:0]  prio_a [NUM_EXC];
    logic [NUM_EXC-1:0] elig;
    logic               nmi_hit;
    logic               found;
    logic [VP_W-1:0]    best_idx;
    logic [PRIO_W-1:0]  best_p;

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_elig
        assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
        if (g == 0 || g == NMI_NUM) begin : g_skip
            assign elig[g] = 1'b0;
        end else begin : g_cand
            assign elig[g] = pend[g] && en[g] && !faultmask &&
                             ((basepri == '0) || (prio_a[g] < basepri));
        end
    end

    assign nmi_hit = pend[NMI_NUM];

    // Linear scan keeping the strictly better candidate
    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_p   = '1;
        for (int i = 0; i < NUM_EXC; i++) begin
            if (elig[i] && (!found || prio_a[i] < best_p)) begin
                found    = 1'b1;
                best_idx = VP_W'(i);
                best_p   = prio_a[i];
            end
        end
    end

    // NMI overrides every other candidate
    always_comb begin
        if (nmi_hit)
            vect = VP_W'(NMI_NUM);
        else
            vect = best_idx;
    end
endmodule

// File: rtl/epc_rd_mux.sv
// Module: assembles the read word from status fields.
// Reserved and write-only bit positions read 0; a non-matching address
// returns 0. Assumes the 32-bit layout given in epc_pkg.
module epc_rd_mux
    import epc_pkg::*;
(
    input  logic             hit,
    input  logic             sv_pend,
    input  logic             tm_pend,
    input  logic             isr,
    input  logic [VP_W-1:0]  vect,
    input  logic             rtb,
    input  logic [ACT_W-1:0] act_num,
    output logic [31:0]      rdata
);
    // Place each field at its bit position, gate by address match
    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[BIT_SV_SET]             = sv_pend;
            rdata[BIT_TM_SET]             = tm_pend;
            rdata[BIT_ISR]                = isr;
            rdata[VP_LSB +: VP_W]         = vect;
            rdata[BIT_RTB]                = rtb;
            rdata[ACT_W-1:0]              = act_num;
        end
    end
endmodule

// File: rtl/exc_pend_ctrl.sv
// Module: exception pending control register (top).
// Decodes writes to the set/clear bits of the supervisor-call and timer
// exceptions, merges their pending state into the pending vector, and
// reports selection and active-stack status in one 32-bit word.
// Assumes NUM_EXC in 17..64 and a single-cycle register bus.
module exc_pend_ctrl
    import epc_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h04,
    parameter int          NUM_EXC  = 32,
    parameter int          PRIO_W   = 3,
    parameter int          CNT_W    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic                      bus_we_i,
    input  logic [31:0]               bus_wdata_i,
    output logic [31:0]               bus_rdata_o,
    input  logic [NUM_EXC-1:0]        exc_pend_i,
    input  logic [NUM_EXC-1:0]        exc_en_i,
    input  logic [NUM_EXC*PRIO_W-1:0] exc_prio_i,
    input  logic [PRIO_W-1:0]         basepri_i,
    input  logic                      faultmask_i,
    input  logic [ACT_W-1:0]          act_num_i,
    input  logic [CNT_W-1:0]          act_cnt_i
);
    localparam logic [NUM_EXC-1:0] SYS_MASK =
        (NUM_EXC'(1) << SVC_NUM) | (NUM_EXC'(1) << TMR_NUM);

    logic                hit;
    logic                wr;
    logic [PB_N-1:0]     sw_set;
    logic [PB_N-1:0]     sw_clr;
    logic [PB_N-1:0]     hw_set;
    logic [PB_N-1:0]     pend_q;
    logic [NUM_EXC-1:0]  eff_pend;
    logic [VP_W-1:0]     vect;
    logic                isr;
    logic                rtb;
    logic                unused_wbits;

    // Address decode and write strobe
    assign hit = (bus_addr_i == ADDR_W'(REG_ADDR));
    assign wr  = hit && bus_we_i;

    // Write-side command bits, ignored unless this register is written
    assign sw_set[PB_SVC] = wr && bus_wdata_i[BIT_SV_SET];
    assign sw_clr[PB_SVC] = wr && bus_wdata_i[BIT_SV_CLR];
    assign sw_set[PB_TMR] = wr && bus_wdata_i[BIT_TM_SET];
    assign sw_clr[PB_TMR] = wr && bus_wdata_i[BIT_TM_CLR];
    assign hw_set[PB_SVC] = 1'b0;
    assign hw_set[PB_TMR] = exc_pend_i[TMR_NUM];

    assign unused_wbits = ^{bus_wdata_i[31:29], bus_wdata_i[24:0]};

    epc_pend_bits #(.N(PB_N)) pend_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .hw_set (hw_set),
        .pend   (pend_q)
    );

    // Replace the two system positions by the register-held state
    always_comb begin
        eff_pend          = exc_pend_i & ~SYS_MASK;
        eff_pend[SVC_NUM] = pend_q[PB_SVC];
        eff_pend[TMR_NUM] = pend_q[PB_TMR];
    end

    epc_prio_sel #(.NUM_EXC(NUM_EXC), .PRIO_W(PRIO_W)) sel_i (
        .pend      (eff_pend),
        .en        (exc_en_i),
        .prio_flat (exc_prio_i),
        .basepri   (basepri_i),
        .faultmask (faultmask_i),
        .vect      (vect)
    );

    // Any external interrupt pending, enable not considered
    assign isr = |eff_pend[NUM_EXC-1:IRQ_BASE];

    // Return reaches thread level when at most one exception is active
    assign rtb = (act_cnt_i <= CNT_W'(1));

    epc_rd_mux rd_i (
        .hit     (hit),
        .sv_pend (pend_q[PB_SVC]),
        .tm_pend (pend_q[PB_TMR]),
        .isr     (isr),
        .vect    (vect),
        .rtb     (rtb),
        .act_num (act_num_i),
        .rdata   (bus_rdata_o)
    );
endmodule

// File: rtl/exc_pend_ctrl_chk.sv
// Module: assertion checker for exc_pend_ctrl, attached by bind.
// Observes bus ports and internal pending state; assumes the top's layout.
module exc_pend_ctrl_chk
    import epc_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] REG_ADDR = 8'h04,
    parameter int         NUM_EXC  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic               bus_we_i,
    input logic [31:0]        bus_wdata_i,
    input logic [31:0]        bus_rdata_o,
    input logic               faultmask_i,
    input logic               sv_pend,
    input logic               tm_pend,
    input logic [NUM_EXC-1:0] eff_pend,
    input logic [VP_W-1:0]    vect
);
    logic c_hit;
    logic c_wr;
    assign c_hit = (bus_addr_i == ADDR_W'(REG_ADDR));
    assign c_wr  = c_hit && bus_we_i;

    a_r1_sv_set: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && bus_wdata_i[BIT_SV_SET] && !bus_wdata_i[BIT_SV_CLR] |=> sv_pend);

    a_r1_sv_only_sw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sv_pend) |-> $past(c_wr && bus_wdata_i[BIT_SV_SET]));

    a_r2_sv_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && bus_wdata_i[BIT_SV_CLR] |=> !sv_pend);

    a_r4_tm_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        c_wr && bus_wdata_i[BIT_TM_CLR] |=> !tm_pend);

    a_r6_sel_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (vect != '0) |-> |(eff_pend & (NUM_EXC'(1) << vect)));

    a_r8_fault_only_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        faultmask_i && (vect != '0) |-> (vect == VP_W'(NMI_NUM)));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_o & RSV_MASK) == '0);

    a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !c_hit |-> (bus_rdata_o == '0));
endmodule

bind exc_pend_ctrl exc_pend_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .NUM_EXC  (NUM_EXC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .faultmask_i (faultmask_i),
    .sv_pend     (pend_q[0]),
    .tm_pend     (pend_q[1]),
    .eff_pend    (eff_pend),
    .vect        (vect)
);

// File: tb/exc_pend_ctrl_tb_top.sv
`timescale 1ns/1ps
module exc_pend_ctrl_tb_top;
    localparam int         ADDR_W = 8;
    localparam logic [7:0] RA     = 8'h04;
    localparam logic [7:0] OA     = 8'h08;
    localparam int         NE     = 32;
    localparam int         PW     = 3;
    localparam int         CW     = 4;
    localparam logic [31:0] RSV   = 32'hE1BC_0600;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] pend;
        logic [31:0] en;
        logic [2:0]  bp;
        logic        fm;
        logic [5:0]  ev;
        logic        ei;
    } row_t;

    // mode 0: all priorities 3; mode 1: 7-(n%8); mode 2: n%8
    localparam row_t TBL [13] = '{
        '{2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 3'd0, 1'b0, 6'd0,  1'b0}, // R6 none
        '{2'd0, 32'h0012_0000, 32'hFFFF_FFFF, 3'd0, 1'b0, 6'd17, 1'b1}, // R6 tie
        '{2'd1, 32'h0082_0000, 32'hFFFF_FFFF, 3'd0, 1'b0, 6'd23, 1'b1}, // R6 value
        '{2'd2, 32'h0082_0008, 32'hFFFF_FFFF, 3'd0, 1'b0, 6'd17, 1'b1}, // R6 value
        '{2'd2, 32'h0000_0008, 32'hFFFF_FFF7, 3'd0, 1'b0, 6'd0,  1'b0}, // R6 enable
        '{2'd2, 32'h0030_0000, 32'hFFFF_FFFF, 3'd4, 1'b0, 6'd0,  1'b1}, // R7 boundary
        '{2'd2, 32'h0018_0000, 32'hFFFF_FFFF, 3'd4, 1'b0, 6'd19, 1'b1}, // R7 below
        '{2'd2, 32'h0001_0004, 32'hFFFF_FFFF, 3'd0, 1'b1, 6'd2,  1'b1}, // R8 nmi
        '{2'd2, 32'h0001_0000, 32'hFFFF_FFFF, 3'd0, 1'b1, 6'd0,  1'b1}, // R8 masked
        '{2'd0, 32'h0004_0000, 32'hFFFF_FFFF, 3'd0, 1'b0, 6'd18, 1'b1}, // R5 single
        '{2'd1, 32'h0080_0004, 32'hFFFF_FFFB, 3'd0, 1'b0, 6'd2,  1'b1}, // R8 over best
        '{2'd2, 32'h0101_0000, 32'hFFFF_FFFF, 3'd0, 1'b0, 6'd16, 1'b1}, // R6 tie
        '{2'd0, 32'h0001_0000, 32'hFFFE_FFFF, 3'd0, 1'b0, 6'd0,  1'b1}  // R5 disabled
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] bus_addr_i;
    logic              bus_we_i;
    logic [31:0]       bus_wdata_i;
    logic [31:0]       bus_rdata_o;
    logic [NE-1:0]     exc_pend_i;
    logic [NE-1:0]     exc_en_i;
    logic [NE*PW-1:0]  exc_prio_i;
    logic [PW-1:0]     basepri_i;
    logic              faultmask_i;
    logic [8:0]        act_num_i;
    logic [CW-1:0]     act_cnt_i;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    exc_pend_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(RA), .NUM_EXC(NE),
                    .PRIO_W(PW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .exc_pend_i(exc_pend_i), .exc_en_i(exc_en_i), .exc_prio_i(exc_prio_i),
        .basepri_i(basepri_i), .faultmask_i(faultmask_i),
        .act_num_i(act_num_i), .act_cnt_i(act_cnt_i)
    );

    function automatic logic [NE*PW-1:0] mk_prio(input logic [1:0] mode);
        logic [NE*PW-1:0] r = '0;
        for (int i = 0; i < NE; i++) begin
            case (mode)
                2'd0:    r[i*PW +: PW] = 3'd3;
                2'd1:    r[i*PW +: PW] = 3'(7 - (i % 8));
                default: r[i*PW +: PW] = 3'(i % 8);
            endcase
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr_i  = a;
        bus_we_i    = 1'b1;
        bus_wdata_i = d;
        @(negedge clk);
        bus_we_i    = 1'b0;
        bus_wdata_i = '0;
        bus_addr_i  = RA;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr_i = a;
        #2;
        d = bus_rdata_o;
        bus_addr_i = RA;
    endtask

    task automatic hw_pulse(input int idx);
        @(negedge clk);
        exc_pend_i[idx] = 1'b1;
        @(negedge clk);
        exc_pend_i[idx] = 1'b0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        bus_addr_i = RA; bus_we_i = 1'b0; bus_wdata_i = '0;
        exc_pend_i = '0; exc_en_i = '1; exc_prio_i = mk_prio(2'd2);
        basepri_i = '0; faultmask_i = 1'b0; act_num_i = '0; act_cnt_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state, only the return-to-base bit set
        do_rd(RA, rv);
        chk("R11 reset word", rv, 32'h0000_0800);

        // Table walk: R5, R6, R7, R8
        foreach (TBL[k]) begin
            @(negedge clk);
            exc_prio_i  = mk_prio(TBL[k].mode);
            exc_pend_i  = TBL[k].pend;
            exc_en_i    = TBL[k].en;
            basepri_i   = TBL[k].bp;
            faultmask_i = TBL[k].fm;
            do_rd(RA, rv);
            chk($sformatf("R5/R6/R7/R8 row %0d", k), rv,
                (32'(TBL[k].ei) << 22) | (32'(TBL[k].ev) << 12) | 32'h800);
        end
        @(negedge clk);
        exc_pend_i = '0; exc_en_i = '1; exc_prio_i = mk_prio(2'd2);
        basepri_i = '0; faultmask_i = 1'b0;

        // R1: software set, read back, selected as number 14
        do_wr(RA, 32'h1000_0000);
        do_rd(RA, rv);
        chk("R1 sv set", rv[28], 1);
        chk("R6 sv selected", 32'(rv[17:12]), 14);
        do_wr(RA, 32'h0000_0000);
        do_rd(RA, rv);
        chk("R1 write 0 no effect", rv[28], 1);
        // R2: clear, then clear-wins
        do_wr(RA, 32'h0800_0000);
        do_rd(RA, rv);
        chk("R2 sv clear", rv[28], 0);
        do_wr(RA, 32'h1800_0000);
        do_rd(RA, rv);
        chk("R2 clear wins", rv[28], 0);
        // R1: hardware input 14 does not set it
        hw_pulse(14);
        do_rd(RA, rv);
        chk("R1 hw ignored", rv[28], 0);
        // R3/R4: timer set, clear read 0, clear
        do_wr(RA, 32'h0400_0000);
        do_rd(RA, rv);
        chk("R3 tm set", rv[26], 1);
        chk("R4 clr bit reads 0", rv[25], 0);
        do_wr(RA, 32'h0200_0000);
        do_rd(RA, rv);
        chk("R4 tm clear", rv[26], 0);
        hw_pulse(15);
        do_rd(RA, rv);
        chk("R3 hw tick sets", rv[26], 1);
        @(negedge clk);
        exc_pend_i[15] = 1'b1;
        do_wr(RA, 32'h0600_0000);
        exc_pend_i[15] = 1'b0;
        do_rd(RA, rv);
        chk("R4 clear beats sets", rv[26], 0);
        // R10: off-address write ignored, off-address read 0, reserved bits
        do_wr(OA, 32'h1400_0000);
        do_rd(RA, rv);
        chk("R10 off-address write", rv, 32'h0000_0800);
        do_rd(OA, rv);
        chk("R10 off-address read", rv, 32'h0);
        do_wr(RA, 32'hFFFF_FFFF);
        do_rd(RA, rv);
        chk("R10 all-ones write", rv, 32'h0000_0800);
        chk("R10 reserved zero", rv & RSV, 32'h0);
        // R9: active number and return-to-base
        @(negedge clk);
        act_num_i = 9'd35; act_cnt_i = 4'd2;
        do_rd(RA, rv);
        chk("R9 nested", rv, 32'h0000_0023);
        act_cnt_i = 4'd1;
        do_rd(RA, rv);
        chk("R9 single", rv, 32'h0000_0823);

        finish_run();
    end
endmodule